// File: doc/BRIEF.md
# Console Receive Register Pair

This block sits between an ideal upstream character receiver and a CPU register bus. It captures each incoming character, or a line break, into a 16-bit receive buffer. That buffer carries error flags in its upper byte. Beside it sits a small status register with a ready flag and an interrupt enable. The CPU selects one of the two registers with `reg_sel`. It reads the buffer to consume a character. A consuming read clears the ready flag, clears the error flags and drops the interrupt, all in one bus access. A line break can also raise a one-cycle halt request toward the processor when the halt-enable input allows it.

Control is centred on a two-state machine. `RX_EMPTY` means no unread character is held and the ready flag reads 0. `RX_FULL` means an unread character is held and the ready flag reads 1. There are four transitions:
- `FILL`: `RX_EMPTY` to `RX_FULL` when a character or break arrives.
- `REFILL`: `RX_FULL` to `RX_FULL` when a character arrives. If no buffer read happens in the same cycle, this is an overrun.
- `DRAIN`: `RX_FULL` to `RX_EMPTY` on a buffer read with no arrival in the same cycle.
- `HOLD`: any state stays put when neither event occurs.

The interrupt request is a registered level. It equals "state is `RX_FULL` and interrupt enable is set". So enabling interrupts while a character is already waiting raises the request at once.

Top module: `con_rx_regs`

## Requirements
- R1: Reset (asynchronous, `rst_n` low) empties the state machine, clears the interrupt enable and the buffer to 0x0000, and holds `irq` and `halt_req` low.
- R2: The status register (`reg_sel`=0) reads the ready flag at bit 7 and the interrupt enable at bit 6, with all other bits 0. A status write updates only the enable, from `reg_wdata[6]`.
- R3: On `rx_valid` the character is latched into buffer bits 7:0 and the ready flag is set. If the enable is 1 after that clock edge, `irq` is high from the next cycle.
- R4: A buffer read (`reg_sel`=1 with `reg_rd`) returns all 16 bits in the read cycle. From the next cycle the ready flag is 0, `irq` is 0, bits 15:8 are 0, and bits 7:0 still hold the character, provided nothing arrives in that cycle.
- R5: A status write with bit 6 = 0 makes `irq` low from the next cycle.
- R6: A status write with bit 6 = 1 while the ready flag is 1 makes `irq` high from the next cycle, even when the character arrived while the enable was 0.
- R7: An arrival with `rx_break` high loads the buffer with bits 15 (error summary), 13 (framing) and 10 (break) set and the character byte 0, giving 0xA400 when no overrun applies.
- R8: A break arrival while `halt_en` is 1 drives `halt_req` high for exactly the next cycle. With `halt_en` at 0, `halt_req` stays low.
- R9: With `mode_8bit` = 0, buffer bit 7 of a received character is stored as 0. With `mode_8bit` = 1, all 8 bits are kept.
- R10: An arrival while the ready flag is 1, with no buffer read in the same cycle, also sets bits 15 (error summary) and 14 (overrun).
- R11: A buffer read and an arrival in the same cycle return the old value on the bus. The new character then stays, the ready flag stays set, and no overrun flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 status, 1 receive buffer |
| reg_rd | input | 1 | Read strobe; with `reg_sel`=1 it consumes the character |
| reg_wr | input | 1 | Write strobe; only the status register is writable |
| reg_wdata | input | 16 | Write data; bit 6 is the interrupt enable |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| rx_valid | input | 1 | One-cycle strobe: a character or break arrived |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Qualifies `rx_valid` as a line break |
| mode_8bit | input | 1 | 1 keeps 8-bit characters, 0 clears bit 7 |
| halt_en | input | 1 | Permits a break to request a halt |
| irq | output | 1 | Level interrupt request |
| halt_req | output | 1 | One-cycle halt request |

## Verification
On every cycle, the embedded assertions check the following: the interrupt follows the ready flag and enable after arrivals, reads and enable writes; a consuming read empties the machine; the halt request is a single registered pulse; and 7-bit mode never stores bit 7. Only the bench's scenarios can show the bus-visible values: the exact bit placement of the status and error flags, the low byte that survives a clearing read, the read-and-arrive collision, and the overrun flags. The bench also sweeps every character code in both modes, and every combination of ready flag, old enable and new enable.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
    localparam int BUF_W  = 16;
    localparam int CHAR_W = 8;

    localparam int B_ERR  = 15;
    localparam int B_OVR  = 14;
    localparam int B_FRM  = 13;
    localparam int B_BRK  = 10;
    localparam int S_DONE = 7;
    localparam int S_IE   = 6;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/con_rx_ctrl.sv
module con_rx_ctrl
    import con_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic data_rd,
    input  logic st_wr,
    input  logic wr_ie,
    output logic done,
    output logic ie,
    output logic irq,
    output logic overrun
);
    rx_state_e state_q, state_d;
    logic      ie_q, ie_d, irq_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (arrive) state_d = RX_FULL;                // FILL
            RX_FULL:  if (data_rd && !arrive) state_d = RX_EMPTY;   // DRAIN
            default:  state_d = RX_EMPTY;
        endcase
        ie_d = st_wr ? wr_ie : ie_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            ie_q  <= ie_d;
            irq_q <= (state_d == RX_FULL) && ie_d;
        end
    end

    assign done    = (state_q == RX_FULL);
    assign ie      = ie_q;
    assign irq     = irq_q;
    assign overrun = arrive && (state_q == RX_FULL) && !data_rd;   // REFILL without read

    a_r3_irq_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && ((st_wr && wr_ie) || (!st_wr && ie_q))) |=> irq);
    a_r4_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !arrive) |=> (!done && !irq));
    a_r5_ie_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !wr_ie) |=> !irq);
    a_r6_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wr_ie && done && !data_rd) |=> irq);
    a_r11_collision_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && data_rd) |=> done);
endmodule

// File: rtl/con_rx_buffer.sv
module con_rx_buffer
    import con_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive,
    input  logic              brk,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              mode_8bit,
    input  logic              overrun,
    input  logic              data_rd,
    output logic [BUF_W-1:0]  buf_q
);
    localparam int HI_W = BUF_W - CHAR_W;

    logic [CHAR_W-1:0] char_m;
    logic [BUF_W-1:0]  load_v;

    always_comb begin
        char_m = char_in;
        if (!mode_8bit) char_m[CHAR_W-1] = 1'b0;
        load_v = '0;
        if (brk) begin
            load_v[B_ERR] = 1'b1;
            load_v[B_FRM] = 1'b1;
            load_v[B_BRK] = 1'b1;
        end else begin
            load_v[CHAR_W-1:0] = char_m;
        end
        if (overrun) begin
            load_v[B_ERR] = 1'b1;
            load_v[B_OVR] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       buf_q <= '0;
        else if (arrive)  buf_q <= load_v;
        else if (data_rd) buf_q <= {{HI_W{1'b0}}, buf_q[CHAR_W-1:0]};
    end

    a_r9_seven_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && !mode_8bit) |=> !buf_q[CHAR_W-1]);
    a_r4_errors_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !arrive) |=> (buf_q[BUF_W-1:CHAR_W] == '0));
    a_r7_break_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && brk) |=> (buf_q[B_ERR] && buf_q[B_FRM] && buf_q[B_BRK]));
endmodule

// File: rtl/con_rx_halt.sv
module con_rx_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic brk,
    input  logic halt_en,
    output logic halt_req
);
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= arrive && brk && halt_en;
    end

    assign halt_req = pulse_q;

    a_r8_halt_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && brk && halt_en) |=> halt_req);
    a_r8_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(arrive && brk && halt_en) |=> !halt_req);
endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
    import con_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [BUF_W-1:0]  reg_wdata,
    output logic [BUF_W-1:0]  reg_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_break,
    input  logic              mode_8bit,
    input  logic              halt_en,
    output logic              irq,
    output logic              halt_req
);
    logic             data_rd, st_wr, done, ie, overrun;
    logic [BUF_W-1:0] buf_q, status_v;

    assign data_rd = reg_rd && reg_sel;
    assign st_wr   = reg_wr && !reg_sel;

    con_rx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arrive  (rx_valid),
        .data_rd (data_rd),
        .st_wr   (st_wr),
        .wr_ie   (reg_wdata[S_IE]),
        .done    (done),
        .ie      (ie),
        .irq     (irq),
        .overrun (overrun)
    );

    con_rx_buffer u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive    (rx_valid),
        .brk       (rx_break),
        .char_in   (rx_data),
        .mode_8bit (mode_8bit),
        .overrun   (overrun),
        .data_rd   (data_rd),
        .buf_q     (buf_q)
    );

    con_rx_halt u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive   (rx_valid),
        .brk      (rx_break),
        .halt_en  (halt_en),
        .halt_req (halt_req)
    );

    always_comb begin
        status_v         = '0;
        status_v[S_DONE] = done;
        status_v[S_IE]   = ie;
    end

    assign reg_rdata = reg_sel ? buf_q : status_v;

    a_r2_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> ((reg_rdata & ~(16'h00C0)) == '0));
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (done && ie));
endmodule

// File: tb/con_rx_regs_tb.sv
module con_rx_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        mode_8bit = 1'b1, halt_en = 1'b0;
    logic        irq, halt_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    con_rx_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .mode_8bit(mode_8bit), .halt_en(halt_en), .irq(irq), .halt_req(halt_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_sel = 0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
        rx_valid = 0; rx_break = 0; rx_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic arrive(input logic brk, input logic [7:0] ch);
        rx_valid = 1; rx_break = brk; rx_data = ch;
        step();
    endtask

    task automatic wr_status(input logic [15:0] d);
        reg_sel = 0; reg_wr = 1; reg_wdata = d;
        step();
    endtask

    task automatic read_data(output logic [15:0] v);
        reg_sel = 1; reg_rd = 1;
        #1 v = reg_rdata;
        step();
    endtask

    task automatic peek(input logic sel, output logic [15:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
        reg_sel = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        idle();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  expch;
        idle();
        @(negedge clk);
        do_reset();

        // R1 reset state
        peek(0, v); chk("R1 status", v, 16'h0000);
        peek(1, v); chk("R1 buffer", v, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 0);
        chk("R1 halt", {15'b0, halt_req}, 0);

        // R2 only IE writable
        wr_status(16'hFFFF); peek(0, v); chk("R2 write ones", v, 16'h0040);
        wr_status(16'h0000); peek(0, v); chk("R2 write zero", v, 16'h0000);

        // R3 R4 R9 sweep of all codes in both modes
        wr_status(16'h0040);
        for (int m = 0; m < 2; m++) begin
            mode_8bit = m[0];
            for (int c = 0; c < 256; c++) begin
                expch = (m == 1) ? 8'(c) : 8'(c % 128);
                arrive(0, 8'(c));
                chk("R3 irq after arrival", {15'b0, irq}, 1);
                peek(0, v); chk("R3 status ready", v, 16'h00C0);
                read_data(v); chk("R9 R4 read value", v, {8'h00, expch});
                peek(0, v); chk("R4 ready cleared", v, 16'h0040);
                chk("R4 irq dropped", {15'b0, irq}, 0);
                peek(1, v); chk("R4 low byte kept", v, {8'h00, expch});
            end
        end
        mode_8bit = 1;

        // R10 overrun with enable off
        wr_status(16'h0000);
        arrive(0, 8'h31); arrive(0, 8'h32);
        chk("R3 no irq when disabled", {15'b0, irq}, 0);
        read_data(v); chk("R10 overrun flags", v, 16'hC032);
        peek(1, v); chk("R10 errors cleared by read", v, 16'h0032);

        // R11 read and arrival collide
        arrive(0, 8'h41);
        reg_sel = 1; reg_rd = 1; rx_valid = 1; rx_data = 8'h42;
        #1 v = reg_rdata; chk("R11 old value read", v, 16'h0041);
        step();
        peek(1, v); chk("R11 new char no overrun", v, 16'h0042);
        peek(0, v); chk("R11 still ready", v, 16'h0080);
        read_data(v);

        // R5 R6 sweep of ready, old enable, new enable
        for (int d = 0; d < 2; d++)
            for (int o = 0; o < 2; o++)
                for (int n = 0; n < 2; n++) begin
                    read_data(v);
                    wr_status(o[0] ? 16'h0040 : 16'h0000);
                    if (d == 1) arrive(0, 8'h55);
                    wr_status(n[0] ? 16'h0040 : 16'h0000);
                    chk((n == 0) ? "R5 irq after enable write" : "R6 irq after enable write",
                        {15'b0, irq}, {15'b0, 1'(d & n)});
                    peek(0, v); chk("R2 status after sweep", v, 16'(d * 128 + n * 64));
                end
        read_data(v);
        wr_status(16'h0000);

        // R7 R8 break with halt enabled
        halt_en = 1;
        arrive(1, 8'h77);
        chk("R8 halt pulse", {15'b0, halt_req}, 1);
        peek(1, v); chk("R7 break value", v, 16'hA400);
        @(negedge clk);
        chk("R8 halt one cycle", {15'b0, halt_req}, 0);
        // break on top of unread char
        arrive(1, 8'h00);
        peek(1, v); chk("R10 R7 break overrun", v, 16'hE400);
        read_data(v);
        // R8 halt disabled
        halt_en = 0;
        arrive(1, 8'h00);
        chk("R8 no halt when disabled", {15'b0, halt_req}, 0);
        @(negedge clk);
        chk("R8 still no halt", {15'b0, halt_req}, 0);

        // R1 reset mid operation
        wr_status(16'h0040);
        arrive(0, 8'h99);
        do_reset();
        peek(0, v); chk("R1 status after reset", v, 16'h0000);
        peek(1, v); chk("R1 buffer after reset", v, 16'h0000);
        chk("R1 irq after reset", {15'b0, irq}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule